// File: doc/BRIEF.md
# Single-Channel Peripheral-Paced DMA Engine

The block is one memory-to-memory copy channel that a peripheral paces through a request/acknowledge pair. Software programs it through a small 32-bit register window: a controller-wide enable word, a channel control word (enable, pause, request-line choice, burst code, burst count), a mode word (beat width, fixed-address flags, interrupt enables, completion status) and the live source and destination addresses.

Once enabled, the channel waits for its selected request line. Each request starts one burst. Every beat is a single read from the source address followed by a single write of that data to the destination address. The address that is not held fixed advances by the beat width after each beat. The burst count counts down as bursts finish. When the last burst ends, the channel switches itself off, posts a completion code and can raise an interrupt. While the transfer runs, software can read back the addresses and the remaining count to work out how much is left.

Top module: `dma_chan`

## Requirements
- R1: Bit 31 of the word at offset 0x00 enables the controller. While it is 0, the channel issues no memory access and no burst makes progress. Once it is set, a waiting transfer proceeds.
- R2: Out of reset, every register reads 0 and `mem_req`, `per_ack` and `irq` are low. The channel words sit at 0x10 (control), 0x14 (mode), 0x18 (source) and 0x1C (destination), and each reads back what was written to it.
- R3: In the control word, bit 31 enables the channel, bit 30 pauses it and bits 28:24 select the request line. A burst starts only when the selected `per_req` bit is high. `per_ack` pulses only on the selected line.
- R4: Control bits 23:20 hold the burst code: 0xF gives 16 beats, 0xD gives 8, 0xB gives 4 and any other code gives 1. A count T in bits 15:0 moves T+1 bursts.
- R5: Each beat reads the source address and then writes the data it read to the destination address. `mem_size` carries the width code.
- R6: Mode bits 27:26 give the beat width: code 0 steps by 1 byte, 1 by 2 bytes and 2 by 4 bytes. Mode bit 25 holds the source address fixed and mode bit 24 holds the destination address fixed.
- R7: While the pause bit is set, no memory access is issued and the addresses stay frozen. Clearing the bit resumes the transfer where it stopped, and the total number of beats is unchanged.
- R8: Clearing the channel enable bit stops all memory access from the next cycle on, without posting completion.
- R9: `per_ack` pulses during the write of the final beat of each burst. After the last burst, the enable bit reads 0 and the status field (mode bits 18:16) reads 0b101.
- R10: `irq` is high when the status is non-zero and the matching enable bit is set: mode bit 19 for status 0b101, mode bit 20 for any other code. Writing the mode word with the status field at 0 drops `irq`.
- R11: During a transfer, the source and destination registers read back the current addresses. The count field drops by one per finished burst, stopping at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Beat width code |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ready | input | 1 | Access completes this cycle |
| per_req | input | 32 | Peripheral request lines |
| per_ack | output | 32 | Peripheral acknowledge, one-hot |
| irq | output | 1 | Interrupt |

## Verification
The bench sweeps every burst-code class (16, 8 and 4 beats, plus a single-beat code) against all three widths, three fixed-address choices and counts of 0 to 2. It does this with memory that is either always ready or stalled pseudo-randomly, which separates beat-count errors from address-step, fixed-flag and data-path errors. Dedicated sequences pause mid-burst, stop mid-transfer, hold the controller off and raise a non-selected request line, to tell freezing, aborting, global gating and line selection apart. One-shot requests leave the channel idle between bursts, so the count and live addresses can be read at known points. Direct writes of status codes separate the two interrupt enables.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int          DW      = 32;
  localparam logic [2:0]  ST_DONE = 3'b101;

  localparam int C_EN     = 31;
  localparam int C_PAUSE  = 30;
  localparam int C_SEL_LO = 24;
  localparam int C_BT_LO  = 20;
  localparam int M_W_LO   = 26;
  localparam int M_FIXS   = 25;
  localparam int M_FIXD   = 24;
  localparam int M_EIE    = 20;
  localparam int M_CIE    = 19;
  localparam int M_ST_LO  = 16;

  typedef enum logic [1:0] {XS_IDLE, XS_WAIT, XS_READ, XS_WRITE} xfer_state_e;

  function automatic logic [4:0] beats_of(input logic [3:0] code);
    case (code)
      4'hF:    return 5'd16;
      4'hD:    return 5'd8;
      4'hB:    return 5'd4;
      default: return 5'd1;
    endcase
  endfunction

  function automatic logic [2:0] step_of(input logic [1:0] wc);
    case (wc)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_chan_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int SEL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              beat_done,
  input  logic              burst_done,
  input  logic              xfer_done,
  output logic              g_en,
  output logic              c_en,
  output logic              c_pause,
  output logic [SEL_W-1:0]  c_sel,
  output logic [3:0]        c_code,
  output logic              c_tc_zero,
  output logic [1:0]        m_wc,
  output logic [2:0]        m_status,
  output logic              m_cie,
  output logic              m_eie,
  output logic [DW-1:0]     src_addr,
  output logic [DW-1:0]     dst_addr
);
  localparam logic [BUS_AW-1:0] OFS_GLB = BUS_AW'(8'h00);
  localparam logic [BUS_AW-1:0] OFS_CTL = BUS_AW'(8'h10);
  localparam logic [BUS_AW-1:0] OFS_MOD = BUS_AW'(8'h14);
  localparam logic [BUS_AW-1:0] OFS_SRC = BUS_AW'(8'h18);
  localparam logic [BUS_AW-1:0] OFS_DST = BUS_AW'(8'h1C);

  logic          glb_q, glb_d;
  logic [DW-1:0] ctl_q, ctl_d, mod_q, mod_d, src_q, src_d, dst_q, dst_d;
  logic          upd;
  logic [DW-1:0] step;

  assign step = DW'(step_of(mod_q[M_W_LO +: 2]));
  assign upd  = bus_we | beat_done | burst_done | xfer_done;

  always_comb begin
    glb_d = glb_q;
    ctl_d = ctl_q;
    mod_d = mod_q;
    src_d = src_q;
    dst_d = dst_q;
    if (beat_done) begin
      if (!mod_q[M_FIXS]) src_d = src_q + step;
      if (!mod_q[M_FIXD]) dst_d = dst_q + step;
    end
    if (burst_done && (ctl_q[15:0] != 16'd0)) ctl_d[15:0] = ctl_q[15:0] - 16'd1;
    if (xfer_done) begin
      ctl_d[C_EN]              = 1'b0;
      mod_d[M_ST_LO +: 3]      = ST_DONE;
    end
    if (bus_we) begin
      case (bus_addr)
        OFS_GLB: glb_d = bus_wdata[31];
        OFS_CTL: ctl_d = bus_wdata;
        OFS_MOD: mod_d = bus_wdata;
        OFS_SRC: src_d = bus_wdata;
        OFS_DST: dst_d = bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= 1'b0;
      ctl_q <= '0;
      mod_q <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else if (upd) begin
      glb_q <= glb_d;
      ctl_q <= ctl_d;
      mod_q <= mod_d;
      src_q <= src_d;
      dst_q <= dst_d;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_GLB: bus_rdata = {glb_q, 31'd0};
      OFS_CTL: bus_rdata = ctl_q;
      OFS_MOD: bus_rdata = mod_q;
      OFS_SRC: bus_rdata = src_q;
      OFS_DST: bus_rdata = dst_q;
      default: bus_rdata = '0;
    endcase
  end

  assign g_en      = glb_q;
  assign c_en      = ctl_q[C_EN];
  assign c_pause   = ctl_q[C_PAUSE];
  assign c_sel     = ctl_q[C_SEL_LO +: SEL_W];
  assign c_code    = ctl_q[C_BT_LO +: 4];
  assign c_tc_zero = (ctl_q[15:0] == 16'd0);
  assign m_wc      = mod_q[M_W_LO +: 2];
  assign m_status  = mod_q[M_ST_LO +: 3];
  assign m_cie     = mod_q[M_CIE];
  assign m_eie     = mod_q[M_EIE];
  assign src_addr  = src_q;
  assign dst_addr  = dst_q;
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
  import dma_chan_pkg::*;
#(
  parameter int NUM_REQ = 32,
  parameter int SEL_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               g_en,
  input  logic               c_en,
  input  logic               c_pause,
  input  logic [SEL_W-1:0]   c_sel,
  input  logic [3:0]         c_code,
  input  logic               c_tc_zero,
  input  logic [DW-1:0]      src_addr,
  input  logic [DW-1:0]      dst_addr,
  input  logic [NUM_REQ-1:0] per_req,
  output logic [NUM_REQ-1:0] per_ack,
  output logic               mem_req,
  output logic               mem_we,
  output logic [DW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  input  logic               mem_ready,
  output logic               beat_done,
  output logic               burst_done,
  output logic               xfer_done
);
  xfer_state_e   st_q, st_d;
  logic [3:0]    beat_q, beat_d;
  logic [DW-1:0] data_q, data_d;
  logic          run, rd_fire, wr_fire, last_beat, upd;

  assign run       = g_en & c_en & ~c_pause;
  assign mem_req   = run & ((st_q == XS_READ) | (st_q == XS_WRITE));
  assign mem_we    = (st_q == XS_WRITE);
  assign mem_addr  = mem_we ? dst_addr : src_addr;
  assign mem_wdata = data_q;
  assign rd_fire   = mem_req & mem_ready & ~mem_we;
  assign wr_fire   = mem_req & mem_ready & mem_we;
  assign last_beat = (beat_q == 4'd0);
  assign beat_done  = wr_fire;
  assign burst_done = wr_fire & last_beat;
  assign xfer_done  = burst_done & c_tc_zero;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_ack
    assign per_ack[i] = burst_done && (c_sel == SEL_W'(i));
  end

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    data_d = data_q;
    if (!c_en) begin
      st_d = XS_IDLE;
    end else begin
      case (st_q)
        XS_IDLE: st_d = XS_WAIT;
        XS_WAIT: begin
          if (run && per_req[c_sel]) begin
            st_d   = XS_READ;
            beat_d = 4'(beats_of(c_code) - 5'd1);
          end
        end
        XS_READ: begin
          if (rd_fire) begin
            st_d   = XS_WRITE;
            data_d = mem_rdata;
          end
        end
        XS_WRITE: begin
          if (wr_fire) begin
            if (last_beat) begin
              st_d = c_tc_zero ? XS_IDLE : XS_WAIT;
            end else begin
              st_d   = XS_READ;
              beat_d = beat_q - 4'd1;
            end
          end
        end
        default: st_d = XS_IDLE;
      endcase
    end
  end

  assign upd = (st_d != st_q) | (beat_d != beat_q) | rd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      beat_q <= '0;
      data_q <= '0;
    end else if (upd) begin
      st_q   <= st_d;
      beat_q <= beat_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int NUM_REQ = 32,
  parameter int BUS_AW  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [1:0]         mem_size,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  input  logic               mem_ready,
  input  logic [NUM_REQ-1:0] per_req,
  output logic [NUM_REQ-1:0] per_ack,
  output logic               irq
);
  localparam int SEL_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic             rst_s;
  logic             g_en, c_en, c_pause, c_tc_zero, m_cie, m_eie;
  logic [SEL_W-1:0] c_sel;
  logic [3:0]       c_code;
  logic [1:0]       m_wc;
  logic [2:0]       m_status;
  logic [DW-1:0]    src_addr, dst_addr;
  logic             beat_done, burst_done, xfer_done;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  dma_regs #(.BUS_AW(BUS_AW), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_s),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .beat_done(beat_done), .burst_done(burst_done), .xfer_done(xfer_done),
    .g_en(g_en), .c_en(c_en), .c_pause(c_pause), .c_sel(c_sel), .c_code(c_code),
    .c_tc_zero(c_tc_zero), .m_wc(m_wc), .m_status(m_status), .m_cie(m_cie),
    .m_eie(m_eie), .src_addr(src_addr), .dst_addr(dst_addr)
  );

  dma_xfer #(.NUM_REQ(NUM_REQ), .SEL_W(SEL_W)) u_xfer (
    .clk(clk), .rst_n(rst_s),
    .g_en(g_en), .c_en(c_en), .c_pause(c_pause), .c_sel(c_sel), .c_code(c_code),
    .c_tc_zero(c_tc_zero), .src_addr(src_addr), .dst_addr(dst_addr),
    .per_req(per_req), .per_ack(per_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .beat_done(beat_done), .burst_done(burst_done), .xfer_done(xfer_done)
  );

  assign mem_size = m_wc;
  assign irq      = (m_status != 3'd0) && ((m_status == ST_DONE) ? m_cie : m_eie);
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int NUM_REQ = 32,
  parameter int BUS_AW  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               g_en,
  input logic               c_en,
  input logic               c_pause,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_ready,
  input logic [NUM_REQ-1:0] per_ack,
  input logic               bus_we,
  input logic [BUS_AW-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               irq
);
  AST_NO_MOVE_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !g_en |-> !mem_req); // R1
  AST_ACK_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_ack)); // R3
  AST_ACK_ON_FINAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|per_ack) |-> (mem_req && mem_we && mem_ready)); // R9
  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    c_pause |-> !mem_req); // R7
  AST_STOP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    !c_en |-> !mem_req); // R8
  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == BUS_AW'(8'h14) && bus_wdata[18:16] == 3'd0) |=> !irq); // R10
endmodule

bind dma_chan dma_chan_chk #(.NUM_REQ(NUM_REQ), .BUS_AW(BUS_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .g_en(g_en), .c_en(c_en), .c_pause(c_pause),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready), .per_ack(per_ack),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq)
);

// File: tb/tb_dma_chan.sv
`timescale 1ns/1ps
module tb_dma_chan;
  localparam int NREQ = 32;
  localparam logic [31:0] SRC0 = 32'h0000_1000;
  localparam logic [31:0] DST0 = 32'h0002_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic mem_req, mem_we;
  logic [1:0] mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic mem_ready = 1'b1;
  logic [NREQ-1:0] per_req = '0;
  logic [NREQ-1:0] per_ack;
  logic irq;

  always #4 clk = ~clk;

  dma_chan dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .per_req(per_req), .per_ack(per_ack), .irq(irq)
  );

  function automatic logic [31:0] fdat(input logic [31:0] a);
    return a * 32'h0019_660D + 32'h3C6E_F35F;
  endfunction
  assign mem_rdata = fdat(mem_addr);

  int checks = 0, errs = 0;
  int nbeat = 0, mism = 0, nack = 0, bad_ack = 0, nreq = 0, cyc = 0;
  logic [31:0] exp_src, exp_dst;
  int wstep = 1;
  bit fs = 0, fd = 0, one_shot = 0, stall_en = 0;
  int sel_cur = 0;
  logic [1:0] wc_cur = 2'd0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    #2;
    if (stall_en) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready = lfsr[0] | lfsr[3];
    end else mem_ready = 1'b1;
  end

  always @(negedge clk) begin
    cyc++;
    if (mem_req) nreq++;
    if (mem_req && mem_ready) begin
      if (!mem_we) begin
        if (mem_addr !== exp_src) mism++;
      end else begin
        if (mem_addr !== exp_dst || mem_wdata !== fdat(exp_src) || mem_size !== wc_cur) mism++;
        nbeat++;
        if (!fs) exp_src = exp_src + wstep;
        if (!fd) exp_dst = exp_dst + wstep;
      end
    end
    if (|per_ack) begin
      nack++;
      if (per_ack !== (NREQ'(1) << sel_cur)) bad_ack++;
      if (one_shot) per_req = '0;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic start(input logic [3:0] code, input logic [1:0] wc, input bit fsi, input bit fdi,
                       input logic [15:0] tc, input bit cie, input int sel);
    sel_cur = sel; fs = fsi; fd = fdi; wc_cur = wc;
    wstep = (wc == 2'd0) ? 1 : (wc == 2'd1) ? 2 : 4;
    exp_src = SRC0; exp_dst = DST0;
    nbeat = 0; mism = 0; nack = 0; bad_ack = 0;
    wr(8'h18, SRC0);
    wr(8'h1C, DST0);
    wr(8'h14, {4'b0, wc, fsi, fdi, 4'b0, cie, 3'b0, 16'b0});
    wr(8'h10, {1'b1, 1'b0, 1'b0, 5'(sel), code, 4'b0, tc});
  endtask

  task automatic wait_done();
    logic [31:0] d;
    for (int i = 0; i < 4000; i++) begin
      rd(8'h10, d);
      if (!d[31]) break;
    end
  endtask

  task automatic wait_beats(input int n);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (nbeat >= n) break;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; errs++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, s0;
    int n0, q0, bts;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state
    rd(8'h00, d); chk("R2 glb reset", d, 0);
    rd(8'h10, d); chk("R2 ctl reset", d, 0);
    rd(8'h14, d); chk("R2 mode reset", d, 0);
    rd(8'h18, d); chk("R2 src reset", d, 0);
    rd(8'h1C, d); chk("R2 dst reset", d, 0);
    chk("R2 outputs reset", {mem_req, irq, |per_ack}, 0);
    wr(8'h18, 32'h1234_5678); rd(8'h18, d); chk("R2 src readback", d, 32'h1234_5678);

    // R1: controller disabled blocks movement
    per_req[4] = 1'b1;
    start(4'hB, 2'd0, 0, 0, 16'd1, 1'b0, 4);
    q0 = nreq;
    repeat (30) @(negedge clk);
    chk("R1 no beats while off", nbeat, 0);
    chk("R1 no requests while off", nreq - q0, 0);
    wr(8'h00, 32'h8000_0000);
    wait_done();
    chk("R1 proceeds after enable", nbeat, 8);
    per_req = '0;

    // Sweep: R4 R5 R6 R9 R10 R11
    for (int code = 0; code < 4; code++) begin
      for (int wc = 0; wc < 3; wc++) begin
        for (int fx = 0; fx < 3; fx++) begin
          for (int tc = 0; tc < 3; tc++) begin
            logic [3:0] cv;
            bit cie;
            cv = (code == 0) ? 4'hF : (code == 1) ? 4'hD : (code == 2) ? 4'hB : 4'h3;
            bts = (code == 0) ? 16 : (code == 1) ? 8 : (code == 2) ? 4 : 1;
            cie = ((code + wc + fx + tc) % 2) == 1;
            stall_en = ((wc + tc) % 2) == 1;
            per_req = '0; per_req[(code * 3 + wc) % NREQ] = 1'b1;
            start(cv, 2'(wc), fx == 1, fx == 2, 16'(tc), cie, (code * 3 + wc) % NREQ);
            wait_done();
            chk("R4 beat count", nbeat, bts * (tc + 1));
            chk("R5 data and address sequence", mism, 0);
            chk("R9 ack per burst", nack, tc + 1);
            chk("R3 ack line", bad_ack, 0);
            rd(8'h18, d); chk("R6 final src", d, (fx == 1) ? SRC0 : SRC0 + 32'(bts * (tc + 1) * wstep));
            rd(8'h1C, d); chk("R6 final dst", d, (fx == 2) ? DST0 : DST0 + 32'(bts * (tc + 1) * wstep));
            rd(8'h10, d); chk("R9 enable cleared", {31'd0, d[31]}, 0);
            chk("R11 count at end", {16'd0, d[15:0]}, 0);
            rd(8'h14, d); chk("R9 status done", {29'd0, d[18:16]}, 5);
            chk("R10 irq follows cie", {31'd0, irq}, {31'd0, cie});
            wr(8'h14, 32'h0);
            chk("R10 irq cleared by ack", {31'd0, irq}, 0);
          end
        end
      end
    end
    stall_en = 0;
    per_req = '0;

    // R3: only the selected line starts a burst
    per_req[3] = 1'b1;
    start(4'hB, 2'd2, 1, 0, 16'd2, 1'b0, 7);
    repeat (30) @(negedge clk);
    chk("R3 wrong line ignored", nbeat, 0);
    per_req[7] = 1'b1;
    wait_done();
    chk("R3 bursts on selected line", nbeat, 12);
    chk("R3 acks only on line 7", bad_ack, 0);
    per_req = '0;

    // R7: pause mid-burst then resume
    per_req[2] = 1'b1;
    start(4'hF, 2'd2, 0, 1, 16'd3, 1'b1, 2);
    wait_beats(19);
    rd(8'h10, d); wr(8'h10, d | 32'h4000_0000);
    repeat (3) @(negedge clk);
    n0 = nbeat; q0 = nreq; rd(8'h18, s0);
    repeat (20) @(negedge clk);
    chk("R7 no beats while paused", nbeat, n0);
    chk("R7 no requests while paused", nreq - q0, 0);
    rd(8'h18, d); chk("R7 src frozen", d, s0);
    rd(8'h10, d); wr(8'h10, d & ~32'h4000_0000);
    wait_done();
    chk("R7 total beats after resume", nbeat, 64);
    chk("R7 sequence intact", mism, 0);
    wr(8'h14, 32'h0);
    per_req = '0;

    // R8: stop mid-transfer
    per_req[1] = 1'b1;
    start(4'hD, 2'd1, 1, 0, 16'd5, 1'b1, 1);
    wait_beats(10);
    rd(8'h10, d); wr(8'h10, d & ~32'h8000_0000);
    repeat (2) @(negedge clk);
    n0 = nbeat; q0 = nreq;
    repeat (20) @(negedge clk);
    chk("R8 no beats after stop", nbeat, n0);
    chk("R8 no requests after stop", nreq - q0, 0);
    rd(8'h14, d); chk("R8 no completion status", {29'd0, d[18:16]}, 0);
    chk("R8 no irq", {31'd0, irq}, 0);
    per_req = '0;

    // R11: count and live address between bursts
    one_shot = 1;
    per_req[5] = 1'b1;
    start(4'hB, 2'd2, 0, 1, 16'd4, 1'b0, 5);
    for (int i = 0; i < 400 && nack < 1; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R11 idle after one burst", nbeat, 4);
    rd(8'h10, d); chk("R11 count after 1 burst", {16'd0, d[15:0]}, 3);
    rd(8'h18, d); chk("R11 live src", d, SRC0 + 32'd16);
    rd(8'h1C, d); chk("R11 fixed dst", d, DST0);
    per_req[5] = 1'b1;
    for (int i = 0; i < 400 && nack < 2; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    rd(8'h10, d); chk("R11 count after 2 bursts", {16'd0, d[15:0]}, 2);
    one_shot = 0;
    per_req[5] = 1'b1;
    wait_done();
    chk("R11 total beats", nbeat, 20);
    per_req = '0;
    wr(8'h14, 32'h0);

    // R10: error-class status uses bit 20 enable
    wr(8'h14, 32'h0013_0000);
    chk("R10 irq on other status with eie", {31'd0, irq}, 1);
    wr(8'h14, 32'h0003_0000);
    chk("R10 no irq without eie", {31'd0, irq}, 0);
    wr(8'h14, 32'h0015_0000);
    chk("R10 done status ignores eie", {31'd0, irq}, 0);
    wr(8'h14, 32'h0010_0000);
    chk("R10 zero status no irq", {31'd0, irq}, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule